// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Scheduler

This block is the issue front end of a SIMT shader cluster. It keeps a pool of eight warps. Each warp has a ready flag and the class of its next instruction: FP32, FP64, INT, SFU or LD/ST. Two independent dispatchers each pick an eligible warp and stream it out as two half-warp beats of 16 threads. A 32-thread warp therefore holds a dispatcher for two consecutive clocks. Each execution group is modelled by a busy counter, and no group takes a new warp until its counter allows it.

The dispatchers work in the same cycle and may serve different warps. Each one searches its own round-robin order. When both want the same warp or the same group, dispatcher 0 wins and dispatcher 1 looks for its next candidate. A long SFU issue blocks only the SFU group; the other groups keep issuing. An FP64 beat and an SFU beat never appear in the same cycle.

A warp's ready flag drops when the warp is picked. An external per-warp load input sets the flag again and supplies the class of the warp's next instruction.

Top module: `warp_dispatch`

## Requirements
- R1: A synchronous active-high reset makes both issue outputs invalid. It also clears every ready flag, every group busy counter and both round-robin pointers, so each dispatcher searches again from warp 0 after reset.
- R2: A picked warp appears on one dispatcher for exactly two consecutive cycles, with the same warp and class, half index 0 and then 1. If a load arrives on clock edge E, the first beat is visible after edge E+1.
- R3: The two dispatchers can issue two different warps in the same cycle, and they never show the same warp in the same cycle.
- R4: The two dispatchers never issue to the same group in the same cycle. On a conflict, dispatcher 0 takes the warp and dispatcher 1 moves on to its next eligible warp or stays idle.
- R5: Class codes are FP32=0, FP64=1, INT=2, SFU=3 and LD/ST=4. Groups handle 32, 16, 32, 4 and 16 threads per clock respectively. After a first beat on a group, no other warp may start on that group for max(32/rate, 2) cycles: SFU 8 cycles, all other groups 2 cycles. Back-to-back starts on a 2-cycle group are allowed.
- R6: While the SFU group is busy, warps of other classes keep issuing on either dispatcher.
- R7: An FP64 beat and an SFU beat are never on the two dispatchers in the same cycle. FP64 may pair with any other class.
- R8: Each dispatcher picks the first eligible warp at or after its pointer, wrapping around the pool. After a pick, the pointer moves to the warp just past the one picked.
- R9: Picking a warp clears its ready flag. A load in the same cycle as the pick wins and sets the flag again with the new class. A warp whose beats are still in flight is never picked by the other dispatcher.
- R10: A load whose class code is 5, 6 or 7 is ignored: the warp's ready flag and class stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 8 | Per-warp load strobe for the next instruction |
| ld_cls | input | 24 | Per-warp 3-bit class code; warp w uses bits [3w+2:3w] |
| d0_valid | output | 1 | Dispatcher 0 beat valid |
| d0_warp | output | 3 | Dispatcher 0 warp id |
| d0_cls | output | 3 | Dispatcher 0 class code |
| d0_half | output | 1 | Dispatcher 0 half index (0 = first 16 threads) |
| d1_valid | output | 1 | Dispatcher 1 beat valid |
| d1_warp | output | 3 | Dispatcher 1 warp id |
| d1_cls | output | 3 | Dispatcher 1 class code |
| d1_half | output | 1 | Dispatcher 1 half index |

## Verification
Each scenario loads a chosen set of warps and classes, and each set tells one rule apart from the others:
- Two warps of different groups show true dual issue.
- Two warps of the same group show dispatcher-0 priority and back-to-back reuse of a 2-cycle group.
- Two SFU warps plus a later INT warp show the 8-cycle SFU hold and prove that the rest of the cluster keeps running during it.
- FP64/SFU pairs in both orders, next to an FP64/FP32 pair, separate the forbidden pairing from a general FP64 stall.
- A full pool of LD/ST warps, and a pointer-offset load, show the round-robin order against a lowest-index-first policy.
- Reload during flight, illegal class codes and a reset in the middle of an SFU hold cover the ready and reset rules.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int WARP_THREADS = 32;
  localparam int HALF_THREADS = 16;
  localparam int NUM_GROUPS   = 5;
  localparam int CLS_W        = 3;
  localparam int NUM_CODES    = 1 << CLS_W;
  localparam int BUSY_W       = 4;

  localparam logic [CLS_W-1:0] CLS_FP32 = 3'd0;
  localparam logic [CLS_W-1:0] CLS_FP64 = 3'd1;
  localparam logic [CLS_W-1:0] CLS_INT  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_SFU  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_LDST = 3'd4;

  // threads per clock each execution group accepts
  function automatic int group_rate(input logic [CLS_W-1:0] c);
    case (c)
      CLS_FP32: return 32;
      CLS_FP64: return 16;
      CLS_INT:  return 32;
      CLS_SFU:  return 4;
      default:  return 16;
    endcase
  endfunction

  function automatic logic cls_legal(input logic [CLS_W-1:0] c);
    return c < CLS_W'(NUM_GROUPS);
  endfunction

  // cycles a group stays reserved: its execution time, never less than the beat pair
  function automatic logic [BUSY_W-1:0] busy_cycles(input logic [CLS_W-1:0] c);
    int occ;
    int beats;
    occ   = WARP_THREADS / group_rate(c);
    beats = WARP_THREADS / HALF_THREADS;
    return BUSY_W'((occ > beats) ? occ : beats);
  endfunction

  function automatic logic forbidden_pair(input logic [CLS_W-1:0] a,
                                          input logic [CLS_W-1:0] b);
    return ((a == CLS_FP64) && (b == CLS_SFU)) || ((a == CLS_SFU) && (b == CLS_FP64));
  endfunction
endpackage

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  // scan from the largest offset down so the nearest candidate is written last
  always_comb begin
    int pos;
    found = 1'b0;
    idx   = '0;
    pos   = 0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = (int'(start) + k) % N;
      if (cand[pos]) begin
        found = 1'b1;
        idx   = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/wd_group_timer.sv
module wd_group_timer #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [BW-1:0] load,
  output logic          free
);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= load;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // free one cycle early: a pick now produces its first beat next cycle
  assign free = (cnt <= BW'(1));

  // R5: every group holds for at least the two beats of a warp
  a_r5_no_back_to_back_start: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
endmodule

// File: rtl/wd_dispatcher.sv
module wd_dispatcher #(
  parameter int NW = 8,
  parameter int IW = $clog2(NW),
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [IW-1:0] pick_warp,
  input  logic [CW-1:0] pick_cls,
  output logic          active,
  output logic          half,
  output logic [IW-1:0] warp,
  output logic [CW-1:0] cls,
  output logic          free,
  output logic [IW-1:0] ptr
);
  function automatic logic [IW-1:0] next_ptr(input logic [IW-1:0] p);
    return (int'(p) == NW - 1) ? '0 : p + 1'b1;
  endfunction

  assign free = !active || half;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      half   <= 1'b0;
      warp   <= '0;
      cls    <= '0;
      ptr    <= '0;
    end else if (free) begin
      half <= 1'b0;
      if (take) begin
        active <= 1'b1;
        warp   <= pick_warp;
        cls    <= pick_cls;
        ptr    <= next_ptr(pick_warp);
      end else begin
        active <= 1'b0;
      end
    end else begin
      half <= 1'b1;
    end
  end

  // R2: the first beat is always followed by the second of the same warp
  a_r2_second_beat: assert property (@(posedge clk) disable iff (rst)
    (active && !half) |=> (active && half && $stable(warp) && $stable(cls)));

  // R2: the selector never hands a warp to a dispatcher in mid-warp
  a_r2_take_only_when_free: assert property (@(posedge clk) disable iff (rst)
    take |-> free);
endmodule

// File: rtl/warp_dispatch.sv
module warp_dispatch
  import wd_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int IW = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       ld_valid,
  input  logic [NUM_WARPS*CLS_W-1:0] ld_cls,
  output logic                       d0_valid,
  output logic [IW-1:0]              d0_warp,
  output logic [CLS_W-1:0]           d0_cls,
  output logic                       d0_half,
  output logic                       d1_valid,
  output logic [IW-1:0]              d1_warp,
  output logic [CLS_W-1:0]           d1_cls,
  output logic                       d1_half
);
  // warp pool
  logic [NUM_WARPS-1:0] rdy;
  logic [CLS_W-1:0]     wcls [NUM_WARPS];

  // dispatcher state
  logic          act0, act1, half0, half1, free0, free1;
  logic [IW-1:0] wk0, wk1, ptr0, ptr1;
  logic [CLS_W-1:0] cls0, cls1;

  // named decision events
  logic          cont0, cont1;
  logic          found0, found1, take0, take1;
  logic [IW-1:0] pick0, pick1;
  logic [CLS_W-1:0] pcls0, pcls1;
  logic          nxt0_valid;
  logic [CLS_W-1:0] nxt0_cls;
  logic [NUM_WARPS-1:0] inflight, elig, cand0, cand1;
  logic [NUM_CODES-1:0] grp_free, grp_start;

  assign cont0 = act0 && !half0;
  assign cont1 = act1 && !half1;

  genvar w;
  generate
    for (w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [CLS_W-1:0] in_cls;
      logic             ld_ok, picked;
      assign in_cls = ld_cls[w*CLS_W +: CLS_W];
      assign ld_ok  = ld_valid[w] && cls_legal(in_cls);
      assign picked = (take0 && pick0 == IW'(w)) || (take1 && pick1 == IW'(w));

      always_ff @(posedge clk) begin
        if (rst) begin
          rdy[w]  <= 1'b0;
          wcls[w] <= '0;
        end else if (ld_ok) begin
          rdy[w]  <= 1'b1;
          wcls[w] <= in_cls;
        end else if (picked) begin
          rdy[w]  <= 1'b0;
        end
      end

      assign inflight[w] = (cont0 && wk0 == IW'(w)) || (cont1 && wk1 == IW'(w));
      assign elig[w]     = rdy[w] && !inflight[w] && grp_free[wcls[w]];
      assign cand0[w]    = elig[w] && !(cont1 && forbidden_pair(wcls[w], cls1));
      assign cand1[w]    = elig[w]
                           && !(take0 && (pick0 == IW'(w) || wcls[w] == pcls0))
                           && !(nxt0_valid && forbidden_pair(wcls[w], nxt0_cls));
    end
  endgenerate

  // dispatcher 0 chooses first
  wd_rr_pick #(.N(NUM_WARPS), .IW(IW)) u_pick0 (
    .cand(cand0), .start(ptr0), .found(found0), .idx(pick0));
  assign take0 = free0 && found0;
  assign pcls0 = wcls[pick0];

  // class dispatcher 0 will show next cycle, seen by dispatcher 1
  assign nxt0_valid = cont0 || take0;
  assign nxt0_cls   = cont0 ? cls0 : pcls0;

  wd_rr_pick #(.N(NUM_WARPS), .IW(IW)) u_pick1 (
    .cand(cand1), .start(ptr1), .found(found1), .idx(pick1));
  assign take1 = free1 && found1;
  assign pcls1 = wcls[pick1];

  wd_dispatcher #(.NW(NUM_WARPS), .IW(IW), .CW(CLS_W)) u_disp0 (
    .clk(clk), .rst(rst), .take(take0), .pick_warp(pick0), .pick_cls(pcls0),
    .active(act0), .half(half0), .warp(wk0), .cls(cls0), .free(free0), .ptr(ptr0));

  wd_dispatcher #(.NW(NUM_WARPS), .IW(IW), .CW(CLS_W)) u_disp1 (
    .clk(clk), .rst(rst), .take(take1), .pick_warp(pick1), .pick_cls(pcls1),
    .active(act1), .half(half1), .warp(wk1), .cls(cls1), .free(free1), .ptr(ptr1));

  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_grp
      if (g < NUM_GROUPS) begin : g_live
        assign grp_start[g] = (take0 && pcls0 == CLS_W'(g)) || (take1 && pcls1 == CLS_W'(g));
        wd_group_timer #(.BW(BUSY_W)) u_timer (
          .clk(clk), .rst(rst), .start(grp_start[g]),
          .load(busy_cycles(CLS_W'(g))), .free(grp_free[g]));
      end else begin : g_unused
        assign grp_start[g] = 1'b0;
        assign grp_free[g]  = 1'b0;
      end
    end
  endgenerate

  assign d0_valid = act0;
  assign d0_warp  = wk0;
  assign d0_cls   = cls0;
  assign d0_half  = half0;
  assign d1_valid = act1;
  assign d1_warp  = wk1;
  assign d1_cls   = cls1;
  assign d1_half  = half1;

  // R3: one warp never occupies both dispatchers
  a_r3_distinct_warps: assert property (@(posedge clk) disable iff (rst)
    (d0_valid && d1_valid) |-> (d0_warp != d1_warp));

  // R4: one group never fed by both dispatchers at once
  a_r4_distinct_groups: assert property (@(posedge clk) disable iff (rst)
    (d0_valid && d1_valid) |-> (d0_cls != d1_cls));

  // R7: FP64 and SFU beats never share a cycle
  a_r7_no_fp64_sfu: assert property (@(posedge clk) disable iff (rst)
    (d0_valid && d1_valid) |-> !forbidden_pair(d0_cls, d1_cls));

  // R2: a second half only ever follows a first half
  a_r2_half_order_d0: assert property (@(posedge clk) disable iff (rst)
    (d0_valid && d0_half) |-> $past(d0_valid && !d0_half));
  a_r2_half_order_d1: assert property (@(posedge clk) disable iff (rst)
    (d1_valid && d1_half) |-> $past(d1_valid && !d1_half));
endmodule

// File: tb/warp_dispatch_test.sv
module warp_dispatch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ld_valid = '0;
  logic [23:0] ld_cls = '0;
  logic        d0_valid, d0_half, d1_valid, d1_half;
  logic [2:0]  d0_warp, d0_cls, d1_warp, d1_cls;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  warp_dispatch uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_cls(ld_cls),
    .d0_valid(d0_valid), .d0_warp(d0_warp), .d0_cls(d0_cls), .d0_half(d0_half),
    .d1_valid(d1_valid), .d1_warp(d1_warp), .d1_cls(d1_cls), .d1_half(d1_half));

  // reservation time from the stated rates: 32 threads / rate, floor of two beats
  function automatic int ref_hold(input int c);
    int rate;
    case (c)
      0, 2:    rate = 32;
      3:       rate = 4;
      default: rate = 16;
    endcase
    return (32 / rate < 2) ? 2 : 32 / rate;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_ld(input int w, input int c);
    ld_valid[w] = 1'b1;
    ld_cls[w*3 +: 3] = 3'(c);
  endtask

  task automatic clr_ld();
    ld_valid = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clr_ld();
    step();
    step();
    rst = 1'b0;
  endtask

  // ev=0 expects an idle dispatcher
  task automatic expect_port(input string tag, input int d, input int ev,
                             input int ew, input int ec, input int eh);
    int av, aw, ac, ah;
    bit bad;
    av = (d == 0) ? int'(d0_valid) : int'(d1_valid);
    aw = (d == 0) ? int'(d0_warp)  : int'(d1_warp);
    ac = (d == 0) ? int'(d0_cls)   : int'(d1_cls);
    ah = (d == 0) ? int'(d0_half)  : int'(d1_half);
    checks++;
    if (ev == 0) bad = (av != 0);
    else         bad = (av != 1) || (aw != ew) || (ac != ec) || (ah != eh);
    if (bad) begin
      errors++;
      $display("FAIL %s d%0d: actual v=%0d w=%0d c=%0d h=%0d expected v=%0d w=%0d c=%0d h=%0d",
               tag, d, av, aw, ac, ah, ev, ew, ec, eh);
    end
  endtask

  // continuous model of group holds, beat pairing and the FP64/SFU rule
  int cyc = 0;
  int last_start [5];
  bit pend [2];
  int pend_w [2];
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      for (int g = 0; g < 5; g++) last_start[g] = -100;
      pend[0] = 0;
      pend[1] = 0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        int v, w, c, h;
        v = (d == 0) ? int'(d0_valid) : int'(d1_valid);
        w = (d == 0) ? int'(d0_warp)  : int'(d1_warp);
        c = (d == 0) ? int'(d0_cls)   : int'(d1_cls);
        h = (d == 0) ? int'(d0_half)  : int'(d1_half);
        if (pend[d]) begin
          checks++;
          if (!(v == 1 && h == 1 && w == pend_w[d])) begin
            errors++;
            $display("FAIL R2 monitor d%0d: actual v=%0d w=%0d h=%0d expected v=1 w=%0d h=1",
                     d, v, w, h, pend_w[d]);
          end
        end
        pend[d] = 0;
        if (v == 1 && h == 0) begin
          checks++;
          if (c > 4) begin
            errors++;
            $display("FAIL R5 monitor d%0d: actual class %0d expected 0..4", d, c);
          end else if (cyc - last_start[c] < ref_hold(c)) begin
            errors++;
            $display("FAIL R5 monitor group %0d: actual gap %0d expected >= %0d",
                     c, cyc - last_start[c], ref_hold(c));
          end else begin
            last_start[c] = cyc;
          end
          pend[d] = 1;
          pend_w[d] = w;
        end
      end
      if (d0_valid && d1_valid) begin
        checks++;
        if ((d0_cls == 3'd1 && d1_cls == 3'd3) || (d0_cls == 3'd3 && d1_cls == 3'd1)) begin
          errors++;
          $display("FAIL R7 monitor: actual classes %0d/%0d expected no FP64+SFU pair",
                   d0_cls, d1_cls);
        end
      end
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    step();
    step();
    expect_port("R1 reset idle", 0, 0, 0, 0, 0);
    expect_port("R1 reset idle", 1, 0, 0, 0, 0);
  endtask

  task automatic t_single();
    do_reset();
    set_ld(5, 0);
    step(); clr_ld();
    step(); expect_port("R2 first half", 0, 1, 5, 0, 0);
    expect_port("R2 d1 idle", 1, 0, 0, 0, 0);
    step(); expect_port("R2 second half", 0, 1, 5, 0, 1);
    step(); expect_port("R9 ready cleared", 0, 0, 0, 0, 0);
    expect_port("R9 ready cleared", 1, 0, 0, 0, 0);
    step(); expect_port("R9 ready cleared", 0, 0, 0, 0, 0);
  endtask

  task automatic t_dual();
    do_reset();
    set_ld(1, 0); set_ld(2, 2);
    step(); clr_ld();
    step(); expect_port("R3 dual d0", 0, 1, 1, 0, 0);
    expect_port("R3 dual d1", 1, 1, 2, 2, 0);
  endtask

  task automatic t_same_group();
    do_reset();
    set_ld(3, 0); set_ld(4, 0);
    step(); clr_ld();
    step(); expect_port("R4 d0 wins", 0, 1, 3, 0, 0);
    expect_port("R4 d1 blocked", 1, 0, 0, 0, 0);
    step(); expect_port("R4 d1 blocked", 1, 0, 0, 0, 0);
    step(); expect_port("R5 back to back", 0, 1, 4, 0, 0);
    expect_port("R4 d1 blocked", 1, 0, 0, 0, 0);
  endtask

  task automatic t_sfu_hold();
    do_reset();
    set_ld(0, 3); set_ld(1, 3); set_ld(2, 0);
    step(); clr_ld();
    step(); expect_port("R5 sfu start", 0, 1, 0, 3, 0);
    expect_port("R6 fp32 beside sfu", 1, 1, 2, 0, 0);
    step();
    step(); expect_port("R5 sfu held", 0, 0, 0, 0, 0);
    set_ld(6, 2);
    step(); clr_ld();
    expect_port("R5 sfu held", 0, 0, 0, 0, 0);
    step(); expect_port("R6 int during sfu", 0, 1, 6, 2, 0);
    step();
    step(); expect_port("R5 sfu held", 0, 0, 0, 0, 0);
    expect_port("R5 sfu held", 1, 0, 0, 0, 0);
    step(); expect_port("R5 sfu held", 0, 0, 0, 0, 0);
    step(); expect_port("R5 sfu after 8", 0, 1, 1, 3, 0);
  endtask

  task automatic t_pairing();
    do_reset();
    set_ld(0, 1); set_ld(1, 3);
    step(); clr_ld();
    step(); expect_port("R7 fp64 first", 0, 1, 0, 1, 0);
    expect_port("R7 sfu held back", 1, 0, 0, 0, 0);
    step(); expect_port("R7 sfu held back", 1, 0, 0, 0, 0);
    step(); expect_port("R7 sfu after fp64", 0, 1, 1, 3, 0);
    do_reset();
    set_ld(0, 3); set_ld(1, 1);
    step(); clr_ld();
    step(); expect_port("R7 sfu first", 0, 1, 0, 3, 0);
    expect_port("R7 fp64 held back", 1, 0, 0, 0, 0);
    step();
    step(); expect_port("R7 fp64 after sfu", 0, 1, 1, 1, 0);
    do_reset();
    set_ld(0, 1); set_ld(1, 0);
    step(); clr_ld();
    step(); expect_port("R7 fp64 pairs", 0, 1, 0, 1, 0);
    expect_port("R7 fp32 pairs", 1, 1, 1, 0, 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int w = 0; w < 8; w++) set_ld(w, 4);
    step(); clr_ld();
    step();
    for (int k = 0; k < 8; k++) begin
      expect_port("R8 pool order", 0, 1, k, 4, 0);
      expect_port("R4 d1 blocked", 1, 0, 0, 0, 0);
      step();
      step();
    end
    do_reset();
    set_ld(1, 0);
    step(); clr_ld();
    step(); expect_port("R8 first pick", 0, 1, 1, 0, 0);
    step();
    set_ld(0, 0); set_ld(3, 0);
    step(); clr_ld();
    step(); expect_port("R8 pointer past 1", 0, 1, 3, 0, 0);
    step();
    step(); expect_port("R8 wrap to 0", 0, 1, 0, 0, 0);
  endtask

  task automatic t_reload();
    do_reset();
    set_ld(0, 0);
    step(); set_ld(0, 2);
    step(); clr_ld();
    expect_port("R9 first instr", 0, 1, 0, 0, 0);
    expect_port("R9 not on d1", 1, 0, 0, 0, 0);
    step(); expect_port("R9 first instr", 0, 1, 0, 0, 1);
    expect_port("R9 not on d1", 1, 0, 0, 0, 0);
    step(); expect_port("R9 reloaded instr", 0, 1, 0, 2, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    set_ld(4, 5); set_ld(5, 7);
    step(); clr_ld();
    for (int k = 0; k < 4; k++) begin
      step();
      expect_port("R10 ignored", 0, 0, 0, 0, 0);
      expect_port("R10 ignored", 1, 0, 0, 0, 0);
    end
    set_ld(4, 2);
    step(); clr_ld();
    step(); expect_port("R10 legal after", 0, 1, 4, 2, 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    set_ld(0, 3); set_ld(1, 3);
    step(); clr_ld();
    step(); expect_port("R1 sfu before reset", 0, 1, 0, 3, 0);
    rst = 1'b1;
    step(); expect_port("R1 reset aborts", 0, 0, 0, 0, 0);
    expect_port("R1 reset aborts", 1, 0, 0, 0, 0);
    rst = 1'b0;
    set_ld(1, 3);
    step(); clr_ld();
    step(); expect_port("R1 busy cleared", 0, 1, 1, 3, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_same_group();
    t_sfu_hold();
    t_pairing();
    t_round_robin();
    t_reload();
    t_illegal();
    t_reset_mid();
    step();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still going expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule